// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block turns a plain serial bit stream into one of four line codes: level-following (NRZ), transition-on-one (NRZI), return-to-zero (RZ) or Manchester. It runs on a clock at twice the bit rate. A strobe marks the first half-bit slot of every incoming bit, so each bit occupies two output slots. The line output is registered. It shows the first-half symbol in the cycle after the strobe edge and the second-half symbol one cycle after that.

The code selector and the data bit are sampled only on a strobe edge. The code then stays fixed for both halves of that bit, so a change of mode lands on a bit boundary. Manchester symbols come from a small Mealy machine. It idles in a waiting state, moves into one of two just-received states when a bit is accepted, and falls back to waiting after emitting the second half. Strobes are expected at least two clock cycles apart. When no bit is in flight, the line holds its level.

Top module: `line_encoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `line_out` is 0. The transition-on-one level starts at 0.
- R2: Mode codes on `code_sel` are 2'b00 NRZ, 2'b01 NRZI, 2'b10 RZ and 2'b11 Manchester. With NRZ, both half slots of a bit equal the data bit.
- R3: With NRZI and a data bit of 1, the line inverts the last NRZI level and keeps the new level for both halves.
- R4: With NRZI and a data bit of 0, the line repeats the last NRZI level for both halves.
- R5: With RZ, a 1 gives high then low, and a 0 gives low in both halves.
- R6: With Manchester, a 0 gives low then high, and a 1 gives high then low.
- R7: The first-half symbol appears on `line_out` after the strobe edge, and the second-half symbol one edge later.
- R8: `code_sel` and `din` are used only on a strobe edge. Changing them during the second half of a bit does not alter that bit's symbols.
- R9: When no strobe arrives, `line_out` keeps its last value after the second half slot.
- R10: The NRZI level is kept across bits sent in other codes. It changes only on NRZI bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock, one edge per half-bit slot |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | High on the edge that starts a new bit |
| din | input | 1 | Data bit, sampled with `bit_stb` |
| code_sel | input | 2 | Line code selector, sampled with `bit_stb` |
| line_out | output | 1 | Encoded line level |

## Verification
On every cycle the assertions check the reset level and the first-half symbol for NRZ, RZ and Manchester. They also check that RZ returns to zero in the second half, that a Manchester bit always flips in mid-bit, and that the line holds when no bit is in flight. Some behaviour depends on history, and only the bench's scenarios can show it. This covers the NRZI level carried through runs of ones and zeros, that level surviving bits sent in other codes, and inputs changed mid-bit being ignored.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

    typedef enum logic [1:0] {
        LC_NRZ  = 2'b00,
        LC_NRZI = 2'b01,
        LC_RZ   = 2'b10,
        LC_MAN  = 2'b11
    } line_code_e;

    typedef enum logic [1:0] {
        MS_WAIT = 2'b00,
        MS_GOT0 = 2'b01,
        MS_GOT1 = 2'b10,
        MS_BAD  = 2'b11
    } man_state_e;

    typedef struct packed {
        line_code_e code;
        logic       data;
    } bit_req_t;

    // Mealy output of the Manchester machine: not q1 and (q0 or data)
    function automatic logic man_symbol(man_state_e st, logic data);
        return ~st[1] & (st[0] | data);
    endfunction

    function automatic man_state_e man_step(man_state_e st, logic accept, logic data);
        man_state_e nx;
        case (st)
            MS_WAIT: nx = accept ? (data ? MS_GOT1 : MS_GOT0) : MS_WAIT;
            MS_GOT0: nx = MS_WAIT;
            MS_GOT1: nx = MS_WAIT;
            default: nx = MS_WAIT;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/lenc_slot_ctrl.sv
module lenc_slot_ctrl
    import lenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       din,
    input  logic [1:0] code_sel,
    output bit_req_t   req_now,
    output line_code_e code_q,
    output logic       second_q
);
    always_comb begin
        req_now.code = line_code_e'(code_sel);
        req_now.data = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= LC_NRZ;
            second_q <= 1'b0;
        end else begin
            second_q <= bit_stb;
            if (bit_stb) code_q <= req_now.code;
        end
    end
endmodule

// File: rtl/lenc_nrzi_level.sv
module lenc_nrzi_level #(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic data,
    output logic level_next
);
    logic level_q;

    always_comb level_next = level_q ^ data;

    always_ff @(posedge clk) begin
        if (rst)          level_q <= RESET_LEVEL;
        else if (advance) level_q <= level_next;
    end
endmodule

// File: rtl/lenc_manchester.sv
module lenc_manchester
    import lenc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic data,
    output logic symbol,
    output logic busy
);
    man_state_e state_q;
    man_state_e state_d;

    always_comb begin
        state_d = man_step(state_q, accept, data);
        symbol  = man_symbol(state_q, data);
        busy    = (state_q != MS_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MS_WAIT;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/line_encoder.sv
module line_encoder
    import lenc_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       din,
    input  logic [1:0] code_sel,
    output logic       line_out
);
    bit_req_t   req_now;
    line_code_e code_q;
    logic       second_q;
    logic       nrzi_next;
    logic       man_sym;
    logic       man_busy;
    logic       man_accept;
    logic       nrzi_adv;
    logic       line_q;
    logic       line_d;

    lenc_slot_ctrl u_slot (
        .clk      (clk),
        .rst      (rst),
        .bit_stb  (bit_stb),
        .din      (din),
        .code_sel (code_sel),
        .req_now  (req_now),
        .code_q   (code_q),
        .second_q (second_q)
    );

    always_comb begin
        nrzi_adv   = bit_stb && (req_now.code == LC_NRZI);
        man_accept = bit_stb && (req_now.code == LC_MAN);
    end

    lenc_nrzi_level #(.RESET_LEVEL(IDLE_LEVEL)) u_nrzi (
        .clk        (clk),
        .rst        (rst),
        .advance    (nrzi_adv),
        .data       (req_now.data),
        .level_next (nrzi_next)
    );

    lenc_manchester u_man (
        .clk    (clk),
        .rst    (rst),
        .accept (man_accept),
        .data   (req_now.data),
        .symbol (man_sym),
        .busy   (man_busy)
    );

    always_comb begin
        line_d = line_q;
        if (bit_stb) begin
            case (req_now.code)
                LC_NRZ:  line_d = req_now.data;
                LC_NRZI: line_d = nrzi_next;
                LC_RZ:   line_d = req_now.data;
                LC_MAN:  line_d = man_sym;
                default: line_d = line_q;
            endcase
        end else if (second_q) begin
            case (code_q)
                LC_RZ:   line_d = 1'b0;
                LC_MAN:  line_d = man_busy ? man_sym : line_q;
                default: line_d = line_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= IDLE_LEVEL;
        else     line_q <= line_d;
    end

    assign line_out = line_q;
endmodule

// File: rtl/line_encoder_chk.sv
module line_encoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_stb,
    input logic       din,
    input logic [1:0] code_sel,
    input logic       line_out
);
    p_reset_low_r1: assert property (@(posedge clk) rst |=> (line_out == 1'b0));

    p_nrz_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && code_sel == 2'b00) |=> (line_out == $past(din)));

    p_rz_first_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && code_sel == 2'b10) |=> (line_out == $past(din)));

    p_rz_second_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && code_sel == 2'b10) |=> ##1 (line_out == 1'b0));

    p_man_first_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && code_sel == 2'b11) |=> (line_out == $past(din)));

    p_man_flip_r7: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && code_sel == 2'b11) |=> ##1 (line_out != $past(line_out)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!bit_stb && !$past(bit_stb) && !$past(rst)) |=> $stable(line_out));
endmodule

bind line_encoder line_encoder_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .din      (din),
    .code_sel (code_sel),
    .line_out (line_out)
);

// File: tb/test_line_encoder.sv
`timescale 1ns/1ps
module test_line_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       din = 1'b0;
    logic [1:0] code_sel = 2'b00;
    logic       line_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic nrzi_lvl = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    line_encoder i_line_encoder (
        .clk      (clk),
        .rst      (rst),
        .bit_stb  (bit_stb),
        .din      (din),
        .code_sel (code_sel),
        .line_out (line_out)
    );

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // d/m held for the strobe edge; d2/m2 presented during the second half
    task automatic send_bit(logic d, logic [1:0] m, logic d2, logic [1:0] m2,
                            output logic f, output logic s);
        @(negedge clk);
        bit_stb = 1'b1; din = d; code_sel = m;
        @(negedge clk);
        f = line_out;
        bit_stb = 1'b0; din = d2; code_sel = m2;
        @(negedge clk);
        s = line_out;
    endtask

    task automatic expect_bit(string req, logic d, logic [1:0] m);
        logic f, s, ef, es;
        send_bit(d, m, d, m, f, s);
        case (m)
            2'b00: begin ef = d; es = d; end
            2'b01: begin nrzi_lvl = nrzi_lvl ^ d; ef = nrzi_lvl; es = nrzi_lvl; end
            2'b10: begin ef = d; es = 1'b0; end
            default: begin ef = d; es = ~d; end
        endcase
        check({req, " first half"}, f, ef);
        check({req, " second half"}, s, es);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 during reset", line_out, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", line_out, 1'b0);
        nrzi_lvl = 1'b0;
    endtask

    task automatic t_nrz();
        expect_bit("R2 nrz 1", 1'b1, 2'b00);
        expect_bit("R2 nrz 0", 1'b0, 2'b00);
        expect_bit("R2 nrz 1b", 1'b1, 2'b00);
    endtask

    task automatic t_nrzi();
        expect_bit("R3 nrzi 1", 1'b1, 2'b01);
        expect_bit("R4 nrzi 0", 1'b0, 2'b01);
        expect_bit("R3 nrzi 1 again", 1'b1, 2'b01);
        expect_bit("R4 nrzi 0 low", 1'b0, 2'b01);
        expect_bit("R3 nrzi rise", 1'b1, 2'b01);
    endtask

    task automatic t_rz();
        expect_bit("R5 rz 1", 1'b1, 2'b10);
        expect_bit("R5 rz 0", 1'b0, 2'b10);
        expect_bit("R5 rz 1b", 1'b1, 2'b10);
    endtask

    task automatic t_man();
        expect_bit("R6 man 0", 1'b0, 2'b11);
        expect_bit("R6 man 1", 1'b1, 2'b11);
        expect_bit("R6 man 1b", 1'b1, 2'b11);
        expect_bit("R7 man 0 after 1", 1'b0, 2'b11);
    endtask

    task automatic t_timing();
        logic v;
        // R7: line still low right at the strobe edge's cycle, high after it
        expect_bit("R7 setup", 1'b0, 2'b00);
        @(negedge clk);
        bit_stb = 1'b1; din = 1'b1; code_sel = 2'b10;
        v = line_out;
        check("R7 before edge", v, 1'b0);
        @(negedge clk);
        check("R7 first slot", line_out, 1'b1);
        bit_stb = 1'b0;
        @(negedge clk);
        check("R7 second slot", line_out, 1'b0);
    endtask

    task automatic t_midbit_change();
        logic f, s;
        send_bit(1'b1, 2'b10, 1'b0, 2'b11, f, s);
        check("R8 rz kept first", f, 1'b1);
        check("R8 rz kept second", s, 1'b0);
        send_bit(1'b0, 2'b11, 1'b1, 2'b00, f, s);
        check("R8 man kept first", f, 1'b0);
        check("R8 man kept second", s, 1'b1);
    endtask

    task automatic t_hold();
        expect_bit("R9 setup man 1", 1'b1, 2'b11);
        repeat (4) @(negedge clk);
        check("R9 hold after man", line_out, 1'b0);
        expect_bit("R9 setup nrz 1", 1'b1, 2'b00);
        repeat (5) @(negedge clk);
        check("R9 hold after nrz", line_out, 1'b1);
    endtask

    task automatic t_nrzi_persist();
        expect_bit("R10 nrzi prep", 1'b1, 2'b01);
        expect_bit("R10 other nrz 0", 1'b0, 2'b00);
        expect_bit("R10 other man 0", 1'b0, 2'b11);
        expect_bit("R10 nrzi 0 keeps", 1'b0, 2'b01);
        expect_bit("R10 nrzi 1 flips", 1'b1, 2'b01);
    endtask

    initial begin
        t_reset();
        t_nrz();
        t_nrzi();
        t_rz();
        t_man();
        t_timing();
        t_midbit_change();
        t_hold();
        t_nrzi_persist();
        t_reset();
        t_nrzi();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule